// File: doc/BRIEF.md
# HDLC Peer Receiver Status and Protocol Violation Monitor

This block sits behind the frame decoder of an HDLC receiver running in automatic link-layer mode. For every decoded frame it is given the frame class, the received N(R), a flag for a present information field, and the local send and acknowledge sequence variables. From these inputs it keeps a record of whether the remote station's receiver is ready or busy. It raises a one-cycle interrupt pulse when that state changes, and a separate pulse when the frame breaks the sequencing or format rules.

A second, independent path watches the clear-to-send pin. The pin is resynchronised to the local clock. A change in either direction produces an interrupt pulse, but only while its enable bit is set. Frame parsing, CRC checking and address matching take place upstream.

Top module: `hdlc_peer_monitor`

## Requirements
- R1: With `autoMode` low, no frame raises `rscPulse` or `pcePulse`, and `remoteBusy` keeps its value.
- R2: An RR frame (class code 0) accepted while `remoteBusy` is 1 clears `remoteBusy` and raises `rscPulse`.
- R3: An RNR frame (class code 1) accepted while `remoteBusy` is 0 sets `remoteBusy` and raises `rscPulse`.
- R4: An RR frame while the peer is already ready, or an RNR frame while it is already busy, raises no `rscPulse` and leaves `remoteBusy` unchanged. REJ (code 2) and other supervisory frames (code 3) never change `remoteBusy`.
- R5: A supervisory frame (codes 0 to 3) or an I-frame (code 4) raises `pcePulse` when its N(R) is invalid. N(R) is valid when, counted modulo 2^SEQ_W upward from V(A), it is reached no later than V(S). The window includes both ends and may wrap past zero.
- R6: A supervisory frame with `infoPresent` set raises `pcePulse` even when its N(R) is valid. An I-frame with an information field and a valid N(R) raises nothing.
- R7: An unnumbered frame (code 5) never raises `pcePulse` or `rscPulse`.
- R8: A rising or falling change on `ctsPin` raises `cscPulse` in the third clock edge after the change, only when `ctsIntEn` is set. With `ctsIntEn` clear, no pulse is raised.
- R9: After reset, `remoteBusy` is 0 and all three pulses are 0.
- R10: The pulses are registered and last exactly one cycle per qualifying event. A frame sampled on edge k shows its result after edge k. Two qualifying frames on consecutive cycles give two consecutive pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | One-cycle strobe: a decoded frame is presented |
| frameClass | input | 3 | 0 RR, 1 RNR, 2 REJ, 3 other supervisory, 4 I-frame, 5 unnumbered |
| rxNr | input | SEQ_W | Received N(R) |
| infoPresent | input | 1 | Frame carried an information field |
| sendSeq | input | SEQ_W | Local V(S) |
| ackSeq | input | SEQ_W | Local V(A) |
| autoMode | input | 1 | Automatic link-layer mode select |
| ctsPin | input | 1 | Asynchronous clear-to-send pin |
| ctsIntEn | input | 1 | Enable for the CTS change interrupt |
| rscPulse | output | 1 | Remote receiver status change pulse |
| pcePulse | output | 1 | Protocol error pulse |
| cscPulse | output | 1 | CTS change pulse |
| remoteBusy | output | 1 | Remote receiver recorded as not ready |

## Verification
The assertions assume that `frameValid` is a single-cycle strobe and that `frameClass`, `rxNr`, `infoPresent`, `sendSeq` and `ackSeq` are stable and meaningful whenever it is high. They also assume that `ctsPin` is low while reset is held, so that the synchroniser starts from a known level. The stimulus drives all frame fields together with the strobe on a falling clock edge and drops the strobe one cycle later. It holds `ctsPin` low through reset, and it spaces CTS toggles far enough apart that each change settles through the synchroniser before the next one.

// File: rtl/hdlc_peer_pkg.sv
package hdlc_peer_pkg;

  typedef enum logic [2:0] {
    FC_RR     = 3'd0,
    FC_RNR    = 3'd1,
    FC_REJ    = 3'd2,
    FC_SOTHER = 3'd3,
    FC_INFO   = 3'd4,
    FC_UNNUM  = 3'd5
  } frameClassE;

  typedef struct packed {
    logic markReady;
    logic markBusy;
    logic raiseRsc;
    logic raisePce;
  } ctrlStrobeS;

endpackage

// File: rtl/peer_ctrl.sv
module peer_ctrl
  import hdlc_peer_pkg::*;
(
  input  logic       frameValid,
  input  frameClassE frameClass,
  input  logic       infoPresent,
  input  logic       autoMode,
  input  logic       nrOk,
  input  logic       remoteBusy,
  output ctrlStrobeS strobe
);

  logic accept;
  logic isSup;
  logic carriesNr;

  assign accept    = frameValid && autoMode;
  assign isSup     = (frameClass == FC_RR) || (frameClass == FC_RNR) ||
                     (frameClass == FC_REJ) || (frameClass == FC_SOTHER);
  assign carriesNr = isSup || (frameClass == FC_INFO);

  always_comb begin
    strobe = '0;
    if (accept) begin
      if (frameClass == FC_RR && remoteBusy) begin
        strobe.markReady = 1'b1;
        strobe.raiseRsc  = 1'b1;
      end
      if (frameClass == FC_RNR && !remoteBusy) begin
        strobe.markBusy = 1'b1;
        strobe.raiseRsc = 1'b1;
      end
      if ((carriesNr && !nrOk) || (isSup && infoPresent))
        strobe.raisePce = 1'b1;
    end
  end

  // R4: ready and busy marks never requested together
  always_comb begin
    assert (!(strobe.markReady && strobe.markBusy))
      else $error("p_exclusive_marks_r4 violated");
  end

endmodule

// File: rtl/peer_datapath.sv
module peer_datapath
  import hdlc_peer_pkg::*;
#(
  parameter int SEQ_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEQ_W-1:0] rxNr,
  input  logic [SEQ_W-1:0] sendSeq,
  input  logic [SEQ_W-1:0] ackSeq,
  input  logic             ctsPin,
  input  logic             ctsIntEn,
  input  ctrlStrobeS       strobe,
  output logic             nrOk,
  output logic             remoteBusy,
  output logic             rscPulse,
  output logic             pcePulse,
  output logic             cscPulse
);

  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [SEQ_W-1:0]  offRx;
  logic [SEQ_W-1:0]  offSend;
  logic [PIPE_W-1:0] ctsPipe;
  logic              ctsChange;

  // distance from V(A), wrapping modulo 2^SEQ_W
  assign offRx   = rxNr - ackSeq;
  assign offSend = sendSeq - ackSeq;
  assign nrOk    = (offRx <= offSend);

  always_ff @(posedge clk) begin
    if (!rstN) ctsPipe <= '0;
    else       ctsPipe <= {ctsPipe[PIPE_W-2:0], ctsPin};
  end

  assign ctsChange = ctsPipe[PIPE_W-1] ^ ctsPipe[PIPE_W-2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remoteBusy <= 1'b0;
      rscPulse   <= 1'b0;
      pcePulse   <= 1'b0;
      cscPulse   <= 1'b0;
    end else begin
      if (strobe.markBusy)       remoteBusy <= 1'b1;
      else if (strobe.markReady) remoteBusy <= 1'b0;
      rscPulse <= strobe.raiseRsc;
      pcePulse <= strobe.raisePce;
      cscPulse <= ctsChange && ctsIntEn;
    end
  end

  // R2: the recorded peer state only moves with a status-change pulse
  p_status_move_r2: assert property (@(posedge clk) disable iff (!rstN)
    (remoteBusy != $past(remoteBusy)) |-> rscPulse);

  // R3: every status-change pulse is backed by a state flip
  p_rsc_flips_r3: assert property (@(posedge clk) disable iff (!rstN)
    rscPulse |-> (remoteBusy != $past(remoteBusy)));

  // R8: CTS pulse only when the enable was set
  p_csc_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    cscPulse |-> $past(ctsIntEn));

endmodule

// File: rtl/hdlc_peer_monitor.sv
module hdlc_peer_monitor
  import hdlc_peer_pkg::*;
#(
  parameter int SEQ_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameValid,
  input  logic [2:0]       frameClass,
  input  logic [SEQ_W-1:0] rxNr,
  input  logic             infoPresent,
  input  logic [SEQ_W-1:0] sendSeq,
  input  logic [SEQ_W-1:0] ackSeq,
  input  logic             autoMode,
  input  logic             ctsPin,
  input  logic             ctsIntEn,
  output logic             rscPulse,
  output logic             pcePulse,
  output logic             cscPulse,
  output logic             remoteBusy
);

  ctrlStrobeS strobe;
  logic       nrOk;

  peer_ctrl u_ctrl (
    .frameValid (frameValid),
    .frameClass (frameClassE'(frameClass)),
    .infoPresent(infoPresent),
    .autoMode   (autoMode),
    .nrOk       (nrOk),
    .remoteBusy (remoteBusy),
    .strobe     (strobe)
  );

  peer_datapath #(.SEQ_W(SEQ_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rxNr      (rxNr),
    .sendSeq   (sendSeq),
    .ackSeq    (ackSeq),
    .ctsPin    (ctsPin),
    .ctsIntEn  (ctsIntEn),
    .strobe    (strobe),
    .nrOk      (nrOk),
    .remoteBusy(remoteBusy),
    .rscPulse  (rscPulse),
    .pcePulse  (pcePulse),
    .cscPulse  (cscPulse)
  );

  // R1: frame interrupts only follow a frame seen in automatic mode
  p_auto_only_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rscPulse || pcePulse) |-> ($past(autoMode) && $past(frameValid)));

  // R7: unnumbered frames never yield a frame interrupt
  p_unnum_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(frameValid) && $past(frameClass) == 3'd5) |-> !(rscPulse || pcePulse));

endmodule

// File: tb/hdlc_peer_monitor_bench.sv
`timescale 1ns/1ps
module hdlc_peer_monitor_bench;

  localparam int SEQ_W = 3;
  localparam int MODV  = 1 << SEQ_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameValid = 1'b0;
  logic [2:0] frameClass = 3'd0;
  logic [SEQ_W-1:0] rxNr = '0;
  logic infoPresent = 1'b0;
  logic [SEQ_W-1:0] sendSeq = '0;
  logic [SEQ_W-1:0] ackSeq = '0;
  logic autoMode = 1'b0;
  logic ctsPin = 1'b0;
  logic ctsIntEn = 1'b0;
  logic rscPulse, pcePulse, cscPulse, remoteBusy;

  always #5 clk = ~clk;

  hdlc_peer_monitor #(.SEQ_W(SEQ_W)) u_hdlc_peer_monitor (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameClass(frameClass),
    .rxNr(rxNr), .infoPresent(infoPresent), .sendSeq(sendSeq), .ackSeq(ackSeq),
    .autoMode(autoMode), .ctsPin(ctsPin), .ctsIntEn(ctsIntEn),
    .rscPulse(rscPulse), .pcePulse(pcePulse), .cscPulse(cscPulse),
    .remoteBusy(remoteBusy)
  );

  typedef struct {
    logic  rsc;
    logic  pce;
    logic  csc;
    logic  busy;
    string tag;
  } expT;

  expT expQ[$];
  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;
  logic modelBusy = 1'b0;

  function automatic bit nrInWindow(int nr, int va, int vs);
    for (int i = 0; i < MODV; i++) begin
      int v;
      v = (va + i) % MODV;
      if (v == nr) return 1'b1;
      if (v == vs) return 1'b0;
    end
    return 1'b0;
  endfunction

  function automatic expT mkExp(logic r, logic p, logic c, string t);
    expT e;
    e.rsc = r; e.pce = p; e.csc = c; e.busy = modelBusy; e.tag = t;
    return e;
  endfunction

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expT e;
      e = expQ.pop_front();
      checks++;
      if (rscPulse !== e.rsc || pcePulse !== e.pce || cscPulse !== e.csc ||
          remoteBusy !== e.busy) begin
        errors++;
        $display("FAIL %s: rsc/pce/csc/busy actual=%b%b%b%b expected=%b%b%b%b",
                 e.tag, rscPulse, pcePulse, cscPulse, remoteBusy,
                 e.rsc, e.pce, e.csc, e.busy);
      end
    end
  end

  task automatic sendFrame(int cls, int nr, bit info, bit am, int va, int vs,
                           bit holdValid, string tag);
    logic expR, expP;
    bit isSup;
    @(negedge clk);
    frameValid = 1'b1; frameClass = 3'(cls); rxNr = SEQ_W'(nr);
    infoPresent = info; autoMode = am; ackSeq = SEQ_W'(va); sendSeq = SEQ_W'(vs);
    isSup = (cls <= 3);
    expR = 1'b0; expP = 1'b0;
    if (am) begin
      if (cls == 0 && modelBusy)  begin expR = 1'b1; modelBusy = 1'b0; end
      if (cls == 1 && !modelBusy) begin expR = 1'b1; modelBusy = 1'b1; end
      if ((isSup || cls == 4) && !nrInWindow(nr, va, vs)) expP = 1'b1;
      if (isSup && info) expP = 1'b1;
    end
    expQ.push_back(mkExp(expR, expP, 1'b0, tag));
    if (!holdValid) begin
      @(negedge clk);
      frameValid = 1'b0;
      expQ.push_back(mkExp(1'b0, 1'b0, 1'b0, {tag, " R10 single pulse"}));
    end
  endtask

  task automatic toggleCts(bit en, string tag);
    @(negedge clk);
    ctsIntEn = en;
    ctsPin = ~ctsPin;
    @(negedge clk);
    @(negedge clk);
    expQ.push_back(mkExp(1'b0, 1'b0, en, tag));
    @(negedge clk);
    expQ.push_back(mkExp(1'b0, 1'b0, 1'b0, {tag, " R10 single pulse"}));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (rscPulse !== 1'b0 || pcePulse !== 1'b0 || cscPulse !== 1'b0 || remoteBusy !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: rsc/pce/csc/busy actual=%b%b%b%b expected=0000",
               rscPulse, pcePulse, cscPulse, remoteBusy);
    end

    sendFrame(0, 3, 0, 1, 2, 5, 0, "R4 RR while ready");
    sendFrame(1, 3, 0, 1, 2, 5, 0, "R3 RNR while ready");
    sendFrame(1, 4, 0, 1, 2, 5, 0, "R4 RNR while busy");
    sendFrame(2, 4, 0, 1, 2, 5, 0, "R4 REJ keeps busy");
    sendFrame(0, 2, 0, 1, 2, 5, 0, "R2 RR while busy");
    sendFrame(1, 3, 0, 0, 2, 5, 0, "R1 RNR in manual mode");
    sendFrame(3, 7, 1, 0, 2, 5, 0, "R1 bad S-frame in manual mode");
    sendFrame(2, 6, 0, 1, 2, 5, 0, "R5 REJ N(R) above window");
    sendFrame(4, 1, 0, 1, 2, 5, 0, "R5 I-frame N(R) below window");
    sendFrame(4, 5, 1, 1, 2, 5, 0, "R6 I-frame info at window top");
    sendFrame(3, 2, 0, 1, 2, 5, 0, "R5 S-frame at window bottom");
    sendFrame(0, 3, 1, 1, 2, 5, 0, "R6 RR with info field");
    sendFrame(5, 7, 1, 1, 2, 5, 0, "R7 unnumbered ignored");
    sendFrame(4, 0, 0, 1, 6, 1, 0, "R5 wrapped window inside");
    sendFrame(4, 3, 0, 1, 6, 1, 0, "R5 wrapped window outside");
    sendFrame(4, 4, 0, 1, 4, 4, 0, "R5 empty window exact");
    sendFrame(1, 4, 0, 1, 4, 4, 1, "R10 back-to-back RNR");
    sendFrame(0, 4, 0, 1, 4, 4, 0, "R10 back-to-back RR");
    toggleCts(1'b1, "R8 CTS rise enabled");
    toggleCts(1'b1, "R8 CTS fall enabled");
    toggleCts(1'b0, "R8 CTS rise disabled");
    toggleCts(1'b0, "R8 CTS fall disabled");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule